// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block sits next to a processor core and decides when the core must enter an exception handler. Three request sources compete: a reset request, a non-maskable interrupt (NMI) and a 3-bit maskable level from an external interrupt controller. The reset and NMI requests are one-cycle pulses that the block latches. The level is a live input that the external controller holds. A level is compared every idle cycle against the enable bit and the level mask in the core's status word (PSW).

When an interrupt is taken, the block snapshots the core's PC, SP and PSW. It saves PC and PSW on the stack through two store requests with valid/ready handshakes. After the second store is accepted, it emits a one-cycle update strobe that carries the new PC, SP and PSW. For a maskable entry it also pulses an acknowledge that carries the served level. A reset request produces a one-cycle pulse to the core instead, with no stores. Seven 16-bit vector registers, one per level 0 to 6, sit behind a small halfword register port. They supply the maskable handler addresses.

Top module: `irq_entry_ctrl`

## Requirements
- R1: When several requests can be served in the same idle cycle, the reset request wins, the NMI comes next, and the maskable level comes last. Each is served in its own sequence.
- R2: A level is taken only if PSW bit 11 (interrupt enable) is 1 and `lvl_i` is strictly below PSW bits 10:8 (level mask). A level of 7 is therefore never taken and means no request.
- R3: An entry first presents a 32-bit store of the PC at SP-4 with `st_half_o`=0, then a 16-bit store of the PSW (zero-extended on `st_data_o`) at SP-8 with `st_half_o`=1. Each store holds its address and data until `st_ready_i` is high.
- R4: `upd_o` is high for exactly one cycle, in the cycle after the PSW store is accepted, with `new_sp_o` = SP-8.
- R5: `new_psw_o` is the snapshot PSW with bit 11 cleared. On a maskable entry, bits 10:8 are also replaced by the served level.
- R6: The new PC is 0x40000000 plus the vector register of the served level for a maskable entry, and 0x40000008 for an NMI.
- R7: On a maskable entry, `ack_o` pulses together with `upd_o`, and `ack_lvl_o` carries the level. The block does not clear the level request, so a level that stays valid and unmasked is taken again.
- R8: An NMI pulse is latched and cleared when taken, so one pulse produces exactly one entry.
- R9: No new arbitration happens while a sequence runs. Requests that arrive meanwhile are held and served afterwards.
- R10: Register map by byte offset: vector n is at 4·n for n=0..6 and is readable and writable. A read-only memory-control value (default 0x0003) is at 0x20. A read-only CPU-mode value (default 0x0001) is at 0x40. Writes elsewhere are ignored and unmapped reads return 0. Vectors reset to 0.
- R11: A write whose `reg_bytes_i` is not 2 sets `reg_err_o` for one cycle on the next cycle and changes no register.
- R12: A taken reset request gives a one-cycle `core_rst_o` pulse with no store and no update, and clears the latched reset request.
- R13: Arbitration is re-evaluated every idle cycle. A level that becomes unmasked through a PSW change is taken with no change on `lvl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req_i | input | 1 | Reset request pulse |
| nmi_req_i | input | 1 | Non-maskable interrupt pulse |
| lvl_i | input | 3 | Pending maskable level, 7 = none |
| pc_i | input | 32 | Core current PC |
| sp_i | input | 32 | Core current SP |
| psw_i | input | 16 | Core current status word |
| st_valid_o | output | 1 | Store request valid |
| st_ready_i | input | 1 | Store request accepted |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |
| st_half_o | output | 1 | 1 = 16-bit store, 0 = 32-bit store |
| upd_o | output | 1 | Strobe to load new PC/SP/PSW |
| new_pc_o | output | 32 | Handler address |
| new_sp_o | output | 32 | Stack pointer after save |
| new_psw_o | output | 16 | Status word after entry |
| ack_o | output | 1 | Maskable entry acknowledge pulse |
| ack_lvl_o | output | 3 | Level being acknowledged |
| core_rst_o | output | 1 | Reset pulse to the core |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte offset |
| reg_bytes_i | input | 3 | Write size in bytes |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| reg_err_o | output | 1 | Bad write size flag |

## Verification
Two functions can meet in one cycle. The first pair is a vector register write and the commit of a maskable entry that reads that same vector for the new PC. The second pair is a fresh NMI pulse and a sequence that is still stalled on its stores. The bench slows `st_ready_i` and pulses the NMI while a level entry is waiting on its stores. It then checks that the NMI entry follows the finished level entry instead of cutting into it. A bench model that steps every cycle and holds its own vector copy judges the commit value for any write timing. Reset and NMI are also raised in the same cycle while a level is valid, and the bench checks the order of the three entries that follow.

// File: rtl/irq_entry_pkg.sv
// Shared types for the interrupt entry controller.
// Assumes: grant and sequencer encodings are private to this block.
package irq_entry_pkg;
    typedef enum logic [1:0] {GR_NONE, GR_RST, GR_NMI, GR_LVL} grant_e;
    typedef enum logic [2:0] {SQ_IDLE, SQ_RST, SQ_SAVE_PC, SQ_SAVE_PSW, SQ_COMMIT} seq_st_e;
endpackage

// File: rtl/irq_vec_regs.sv
// Vector register file with a halfword register port.
// Holds NVEC writable vectors at a 4-byte stride plus two read-only
// constants. Writes of any size but 2 bytes flag an error and change nothing.
// Assumes: reads are combinational on the address; one write per cycle.
module irq_vec_regs #(
    parameter int          NVEC       = 7,
    parameter int          ADDR_W     = 7,
    parameter int          RW         = 16,
    parameter int          IDX_W      = 3,
    parameter logic [6:0]  MEMCTL_OFS = 7'h20,
    parameter logic [6:0]  MODE_OFS   = 7'h40,
    parameter logic [15:0] MEMCTL_VAL = 16'h0003,
    parameter logic [15:0] MODE_VAL   = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bytes,
    input  logic [RW-1:0]     wdata,
    output logic [RW-1:0]     rdata,
    output logic              err,
    input  logic [IDX_W-1:0]  vec_idx,
    output logic [RW-1:0]     vec_data
);
    localparam int SLOT_W = ADDR_W - 2;
    localparam logic [SLOT_W-1:0] NVEC_S = SLOT_W'(NVEC);
    localparam logic [IDX_W-1:0]  NVEC_I = IDX_W'(NVEC);

    logic [NVEC-1:0][RW-1:0] vec_q;
    logic [SLOT_W-1:0]       slot;
    logic                    in_vec;
    logic                    size_ok;
    logic [NVEC-1:0]         hit;
    logic                    err_q;

    assign slot    = addr[ADDR_W-1:2];
    assign in_vec  = (addr[1:0] == 2'b00) && (slot < NVEC_S);
    assign size_ok = (bytes == 3'd2);

    // Per-vector address decode.
    for (genvar i = 0; i < NVEC; i++) begin : g_hit
        assign hit[i] = in_vec && (slot == SLOT_W'(i));
    end

    // Vector storage: a correctly sized write to a mapped vector updates it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (wr_en && size_ok) begin
            for (int i = 0; i < NVEC; i++) begin
                if (hit[i]) vec_q[i] <= wdata;
            end
        end
    end

    // Error flag: one cycle after a write of the wrong width.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= wr_en && !size_ok;
    end
    assign err = err_q;

    // Read mux: vectors, the two constants, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (in_vec)                  rdata = vec_q[slot[IDX_W-1:0]];
        else if (addr == MEMCTL_OFS) rdata = MEMCTL_VAL;
        else if (addr == MODE_OFS)   rdata = MODE_VAL;
    end

    // Vector lookup for the entry sequencer.
    assign vec_data = (vec_idx < NVEC_I) ? vec_q[vec_idx] : '0;

    // R11: a wrongly sized write leaves every vector untouched.
    a_r11_bad_size_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !size_ok) |=> $stable(vec_q));
    // R10: writes outside the vector window leave every vector untouched.
    a_r10_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_vec) |=> $stable(vec_q));
endmodule

// File: rtl/irq_arbiter.sv
// Request latching and priority arbitration.
// Latches reset and NMI pulses, qualifies the live level against the PSW,
// and grants one source per idle cycle in fixed priority order.
// Assumes: the sequencer accepts any grant issued while idle_i is high.
module irq_arbiter
    import irq_entry_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int PSW_W  = 16,
    parameter int IE_BIT = 11,
    parameter int LM_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req_i,
    input  logic             nmi_req_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [PSW_W-1:0] psw_i,
    input  logic             idle_i,
    output grant_e           grant_o
);
    logic rst_pend;
    logic nmi_pend;
    logic lvl_ok;

    assign lvl_ok = psw_i[IE_BIT] && (lvl_i < psw_i[LM_LSB +: LVL_W]);

    // Priority selection, only while the sequencer is idle.
    always_comb begin
        grant_o = GR_NONE;
        if (idle_i) begin
            if (rst_pend)      grant_o = GR_RST;
            else if (nmi_pend) grant_o = GR_NMI;
            else if (lvl_ok)   grant_o = GR_LVL;
        end
    end

    // Pending latches: cleared when granted, a new pulse always wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pend <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            rst_pend <= (rst_pend && (grant_o != GR_RST)) || rst_req_i;
            nmi_pend <= (nmi_pend && (grant_o != GR_NMI)) || nmi_req_i;
        end
    end

    // R9: a pending NMI survives a busy sequencer.
    a_r9_nmi_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_i && nmi_pend) |=> nmi_pend);
    // R8: a granted NMI is consumed unless a fresh pulse arrives.
    a_r8_nmi_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == GR_NMI && !nmi_req_i) |=> !nmi_pend);
endmodule

// File: rtl/irq_entry_seq.sv
// Entry sequencer: snapshots core state on a grant, issues the PC and PSW
// stack stores, then commits the new PC/SP/PSW in one strobe cycle.
// Assumes: the core holds its state stable and reacts only to upd_o.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          PSW_W    = 16,
    parameter int          LVL_W    = 3,
    parameter int          RW       = 16,
    parameter int          IE_BIT   = 11,
    parameter int          LM_LSB   = 8,
    parameter logic [31:0] VEC_BASE = 32'h4000_0000,
    parameter logic [31:0] NMI_PC   = 32'h4000_0008
) (
    input  logic             clk,
    input  logic             rst_n,
    input  grant_e           grant_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  sp_i,
    input  logic [PSW_W-1:0] psw_i,
    output logic             idle_o,
    output logic [LVL_W-1:0] vec_idx_o,
    input  logic [RW-1:0]    vec_data_i,
    output logic             st_valid_o,
    input  logic             st_ready_i,
    output logic [XLEN-1:0]  st_addr_o,
    output logic [XLEN-1:0]  st_data_o,
    output logic             st_half_o,
    output logic             upd_o,
    output logic [XLEN-1:0]  new_pc_o,
    output logic [XLEN-1:0]  new_sp_o,
    output logic [PSW_W-1:0] new_psw_o,
    output logic             ack_o,
    output logic [LVL_W-1:0] ack_lvl_o,
    output logic             core_rst_o
);
    seq_st_e          state;
    logic             is_lvl;
    logic [LVL_W-1:0] lvl_q;
    logic [XLEN-1:0]  pc_q;
    logic [XLEN-1:0]  sp_q;
    logic [PSW_W-1:0] psw_q;

    // State walk and snapshot capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            is_lvl <= 1'b0;
            lvl_q  <= '0;
            pc_q   <= '0;
            sp_q   <= '0;
            psw_q  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (grant_i == GR_RST) begin
                        state <= SQ_RST;
                    end else if (grant_i != GR_NONE) begin
                        state  <= SQ_SAVE_PC;
                        is_lvl <= (grant_i == GR_LVL);
                        lvl_q  <= lvl_i;
                        pc_q   <= pc_i;
                        sp_q   <= sp_i;
                        psw_q  <= psw_i;
                    end
                end
                SQ_RST:      state <= SQ_IDLE;
                SQ_SAVE_PC:  if (st_ready_i) state <= SQ_SAVE_PSW;
                SQ_SAVE_PSW: if (st_ready_i) state <= SQ_COMMIT;
                SQ_COMMIT:   state <= SQ_IDLE;
                default:     state <= SQ_IDLE;
            endcase
        end
    end

    assign idle_o     = (state == SQ_IDLE);
    assign core_rst_o = (state == SQ_RST);
    assign vec_idx_o  = lvl_q;

    // Store request drive for the two save steps.
    always_comb begin
        st_valid_o = (state == SQ_SAVE_PC) || (state == SQ_SAVE_PSW);
        st_half_o  = (state == SQ_SAVE_PSW);
        st_addr_o  = st_half_o ? (sp_q - XLEN'(8)) : (sp_q - XLEN'(4));
        st_data_o  = st_half_o ? {{(XLEN-PSW_W){1'b0}}, psw_q} : pc_q;
    end

    // Commit values for the update strobe.
    always_comb begin
        upd_o     = (state == SQ_COMMIT);
        ack_o     = upd_o && is_lvl;
        ack_lvl_o = lvl_q;
        new_sp_o  = sp_q - XLEN'(8);
        new_pc_o  = is_lvl ? (VEC_BASE + {{(XLEN-RW){1'b0}}, vec_data_i}) : NMI_PC;
        new_psw_o = psw_q;
        new_psw_o[IE_BIT] = 1'b0;
        if (is_lvl) new_psw_o[LM_LSB +: LVL_W] = lvl_q;
    end

    // R3: a stalled store keeps its request stable.
    a_r3_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_o && !st_ready_i) |=> (st_valid_o && $stable(st_addr_o) && $stable(st_data_o)));
    // R4: the commit directly follows an accepted PSW store.
    a_r4_commit_after_psw: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(st_valid_o && st_half_o && st_ready_i));
    // R4: the update strobe lasts a single cycle.
    a_r4_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);
    // R5: interrupts are disabled in every committed status word.
    a_r5_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> !new_psw_o[IE_BIT]);
    // R7: acknowledge only ever accompanies a commit.
    a_r7_ack_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> upd_o);
    // R12: a reset pulse is single and followed by no store.
    a_r12_rst_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> (!core_rst_o && !st_valid_o && !upd_o));
endmodule

// File: rtl/irq_entry_ctrl.sv
// Top of the interrupt entry controller: arbiter, entry sequencer and
// vector register file.
// Assumes: synchronous active-low reset; request pulses are one cycle wide.
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          PSW_W      = 16,
    parameter int          LVL_W      = 3,
    parameter int          ADDR_W     = 7,
    parameter int          RW         = 16,
    parameter int          IE_BIT     = 11,
    parameter int          LM_LSB     = 8,
    parameter logic [31:0] VEC_BASE   = 32'h4000_0000,
    parameter logic [31:0] NMI_PC     = 32'h4000_0008,
    parameter logic [15:0] MEMCTL_VAL = 16'h0003,
    parameter logic [15:0] MODE_VAL   = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req_i,
    input  logic              nmi_req_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   sp_i,
    input  logic [PSW_W-1:0]  psw_i,
    output logic              st_valid_o,
    input  logic              st_ready_i,
    output logic [XLEN-1:0]   st_addr_o,
    output logic [XLEN-1:0]   st_data_o,
    output logic              st_half_o,
    output logic              upd_o,
    output logic [XLEN-1:0]   new_pc_o,
    output logic [XLEN-1:0]   new_sp_o,
    output logic [PSW_W-1:0]  new_psw_o,
    output logic              ack_o,
    output logic [LVL_W-1:0]  ack_lvl_o,
    output logic              core_rst_o,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [2:0]        reg_bytes_i,
    input  logic [RW-1:0]     reg_wdata_i,
    output logic [RW-1:0]     reg_rdata_o,
    output logic              reg_err_o
);
    localparam int NVEC = (1 << LVL_W) - 1;

    grant_e           grant;
    logic             idle;
    logic [LVL_W-1:0] vec_idx;
    logic [RW-1:0]    vec_data;

    irq_arbiter #(
        .LVL_W(LVL_W), .PSW_W(PSW_W), .IE_BIT(IE_BIT), .LM_LSB(LM_LSB)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i), .nmi_req_i(nmi_req_i),
        .lvl_i(lvl_i), .psw_i(psw_i), .idle_i(idle), .grant_o(grant)
    );

    irq_entry_seq #(
        .XLEN(XLEN), .PSW_W(PSW_W), .LVL_W(LVL_W), .RW(RW), .IE_BIT(IE_BIT),
        .LM_LSB(LM_LSB), .VEC_BASE(VEC_BASE), .NMI_PC(NMI_PC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .grant_i(grant), .lvl_i(lvl_i),
        .pc_i(pc_i), .sp_i(sp_i), .psw_i(psw_i), .idle_o(idle),
        .vec_idx_o(vec_idx), .vec_data_i(vec_data),
        .st_valid_o(st_valid_o), .st_ready_i(st_ready_i), .st_addr_o(st_addr_o),
        .st_data_o(st_data_o), .st_half_o(st_half_o), .upd_o(upd_o),
        .new_pc_o(new_pc_o), .new_sp_o(new_sp_o), .new_psw_o(new_psw_o),
        .ack_o(ack_o), .ack_lvl_o(ack_lvl_o), .core_rst_o(core_rst_o)
    );

    irq_vec_regs #(
        .NVEC(NVEC), .ADDR_W(ADDR_W), .RW(RW), .IDX_W(LVL_W),
        .MEMCTL_OFS(7'h20), .MODE_OFS(7'h40),
        .MEMCTL_VAL(MEMCTL_VAL), .MODE_VAL(MODE_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_i), .addr(reg_addr_i),
        .bytes(reg_bytes_i), .wdata(reg_wdata_i), .rdata(reg_rdata_o),
        .err(reg_err_o), .vec_idx(vec_idx), .vec_data(vec_data)
    );
endmodule

// File: tb/irq_entry_ctrl_test.sv
// Bench: a behavioural model stepped on every clock and compared to the
// design outputs, plus directed scenarios judged on the order of entries.
module irq_entry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 1'b0, nmi_req = 1'b0;
    logic [2:0]  lvl = 3'd7;
    logic [31:0] pc = 32'h0000_1234, sp = 32'h0000_8000;
    logic [15:0] psw = 16'h0000;
    logic        st_valid, st_ready = 1'b1, st_half, upd, ack, core_rst;
    logic [31:0] st_addr, st_data, new_pc, new_sp;
    logic [15:0] new_psw;
    logic [2:0]  ack_lvl;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = 7'h00;
    logic [2:0]  reg_bytes = 3'd2;
    logic [15:0] reg_wdata = 16'h0, reg_rdata;
    logic        reg_err;

    irq_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .nmi_req_i(nmi_req),
        .lvl_i(lvl), .pc_i(pc), .sp_i(sp), .psw_i(psw),
        .st_valid_o(st_valid), .st_ready_i(st_ready), .st_addr_o(st_addr),
        .st_data_o(st_data), .st_half_o(st_half), .upd_o(upd),
        .new_pc_o(new_pc), .new_sp_o(new_sp), .new_psw_o(new_psw),
        .ack_o(ack), .ack_lvl_o(ack_lvl), .core_rst_o(core_rst),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_bytes_i(reg_bytes),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .reg_err_o(reg_err)
    );

    always #5 clk = ~clk;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit slow_ready = 1'b0;
    int ev_q[$];   // 1 = reset pulse, 2 = NMI entry, 10+L = level L entry

    // reference model state
    int          m_phase = 0;
    bit          m_rp = 0, m_np = 0, m_kl = 0;
    int          m_lvl = 0;
    logic [31:0] m_pc = 0, m_sp = 0;
    logic [15:0] m_psw = 0;
    logic [15:0] m_vec [7];
    bit          m_err = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] m_read(logic [6:0] a);
        if (a[1:0] == 2'b00 && a[6:2] < 7) return m_vec[a[6:2]];
        if (a == 7'h20) return 16'h0003;
        if (a == 7'h40) return 16'h0001;
        return 16'h0000;
    endfunction

    // Model step on each rising edge, from the inputs the bench holds stable.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_rp = 0; m_np = 0; m_err = 0; m_kl = 0;
            for (int i = 0; i < 7; i++) m_vec[i] = 16'h0;
        end else begin
            if (reg_wr && reg_bytes == 3'd2 && reg_addr[1:0] == 2'b00 && reg_addr[6:2] < 7)
                m_vec[reg_addr[6:2]] = reg_wdata;
            m_err = reg_wr && (reg_bytes != 3'd2);
            case (m_phase)
                0: begin
                    if (m_rp) begin m_rp = 0; m_phase = 1; end
                    else if (m_np) begin
                        m_np = 0; m_kl = 0; m_pc = pc; m_sp = sp; m_psw = psw; m_phase = 2;
                    end else if (psw[11] && int'(lvl) < int'(psw[10:8])) begin
                        m_kl = 1; m_lvl = int'(lvl); m_pc = pc; m_sp = sp; m_psw = psw; m_phase = 2;
                    end
                end
                1: m_phase = 0;
                2: if (st_ready) m_phase = 3;
                3: if (st_ready) m_phase = 4;
                default: m_phase = 0;
            endcase
            if (rst_req) m_rp = 1;
            if (nmi_req) m_np = 1;
        end
    end

    // Compare away from the edge; also log entries in order.
    always @(posedge clk) begin
        #2;
        if (cyc >= 3) begin
            logic [15:0] ep;
            check("R3 st_valid", 32'(st_valid), 32'(m_phase == 2 || m_phase == 3));
            if (m_phase == 2) begin
                check("R3 pc store addr", st_addr, m_sp - 4);
                check("R3 pc store data", st_data, m_pc);
                check("R3 pc store size", 32'(st_half), 0);
            end
            if (m_phase == 3) begin
                check("R3 psw store addr", st_addr, m_sp - 8);
                check("R3 psw store data", st_data, {16'h0, m_psw});
                check("R3 psw store size", 32'(st_half), 1);
            end
            check("R4 upd", 32'(upd), 32'(m_phase == 4));
            check("R12 core_rst", 32'(core_rst), 32'(m_phase == 1));
            check("R7 ack", 32'(ack), 32'(m_phase == 4 && m_kl));
            if (m_phase == 4) begin
                check("R4 new_sp", new_sp, m_sp - 8);
                ep = m_psw & 16'hF7FF;
                if (m_kl) ep = (ep & 16'hF8FF) | 16'(m_lvl << 8);
                check("R5 new_psw", 32'(new_psw), 32'(ep));
                check("R6 new_pc", new_pc,
                      m_kl ? 32'h4000_0000 + 32'(m_vec[m_lvl]) : 32'h4000_0008);
                if (m_kl) check("R7 ack_lvl", 32'(ack_lvl), m_lvl);
            end
            check("R10 reg_rdata", 32'(reg_rdata), 32'(m_read(reg_addr)));
            check("R11 reg_err", 32'(reg_err), 32'(m_err));
            if (core_rst) ev_q.push_back(1);
            if (upd) ev_q.push_back(ack ? 10 + int'(ack_lvl) : 2);
        end
    end

    // Store ready pattern, changed on the falling edge.
    always @(negedge clk) st_ready = slow_ready ? (cyc % 3 == 2) : 1'b1;

    // Watchdog: a hung run counts as a failure.
    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [6:0] a, logic [15:0] d, logic [2:0] b);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d; reg_bytes = b;
        @(negedge clk);
        reg_wr = 0; reg_bytes = 3'd2;
    endtask

    task automatic reg_expect(string req, logic [6:0] a, logic [15:0] e);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, 32'(reg_rdata), 32'(e));
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1;
        wait_cyc(2);
        // reset state
        check("R10 reset vector0", 32'(reg_rdata), 0);
        check("R4 reset upd", 32'(upd), 0);

        // register map
        for (int i = 0; i < 7; i++) reg_write(7'(4 * i), 16'(16'h0100 * (i + 1) + i), 3'd2);
        reg_write(7'h20, 16'hBEEF, 3'd2);
        reg_write(7'h1C, 16'hBEEF, 3'd2);
        reg_expect("R10 vector6", 7'h18, 16'h0706);
        reg_expect("R10 memctl read-only", 7'h20, 16'h0003);
        reg_expect("R10 cpu mode", 7'h40, 16'h0001);
        reg_expect("R10 unmapped 0x1C", 7'h1C, 16'h0000);
        reg_expect("R10 unmapped 0x02", 7'h02, 16'h0000);
        @(negedge clk); reg_wr = 1; reg_addr = 7'h00; reg_wdata = 16'hDEAD; reg_bytes = 3'd1;
        @(negedge clk); reg_wr = 0; reg_bytes = 3'd2;
        check("R11 err flag", 32'(reg_err), 1);
        reg_expect("R11 vector0 unchanged", 7'h00, 16'h0100);

        // NMI alone, interrupts disabled
        ev_q.delete();
        @(negedge clk); nmi_req = 1; @(negedge clk); nmi_req = 0;
        wait_cyc(12);
        check("R8 one NMI entry", ev_q.size(), 1);
        if (ev_q.size() > 0) check("R8 entry kind", ev_q[0], 2);

        // masked levels, then unmask via PSW only
        ev_q.delete();
        psw = 16'h0800 | 16'h0300; lvl = 3'd3;
        wait_cyc(8);
        check("R2 equal level not taken", ev_q.size(), 0);
        psw = 16'h0800 | 16'h0400; pc = 32'h0000_2000;
        wait_cyc(14);
        check("R13 taken on PSW change", 32'(ev_q.size() >= 1), 1);
        if (ev_q.size() > 0) check("R13 level 3 served", ev_q[0], 13);
        check("R7 level not cleared, retaken", 32'(ev_q.size() >= 2), 1);
        lvl = 3'd7;
        wait_cyc(8);
        ev_q.delete();
        psw = 16'h0700;
        lvl = 3'd0;
        wait_cyc(8);
        psw = 16'h0F00; lvl = 3'd7;
        wait_cyc(8);
        check("R2 IE off or level 7 not taken", ev_q.size(), 0);

        // priority: reset and NMI together with a valid level
        ev_q.delete();
        @(negedge clk); rst_req = 1; nmi_req = 1; psw = 16'h0F00; lvl = 3'd7;
        @(negedge clk); rst_req = 0; nmi_req = 0; lvl = 3'd2;
        wait_cyc(16);
        lvl = 3'd7;
        wait_cyc(8);
        check("R1 count", 32'(ev_q.size() >= 3), 1);
        if (ev_q.size() >= 3) begin
            check("R12 reset first", ev_q[0], 1);
            check("R1 NMI second", ev_q[1], 2);
            check("R1 level third", ev_q[2], 12);
        end

        // NMI arrives while a level entry is stalled on its stores
        ev_q.delete();
        slow_ready = 1; sp = 32'h0000_4000;
        @(negedge clk); lvl = 3'd1;
        for (int k = 0; k < 20 && !st_valid; k++) @(negedge clk);
        nmi_req = 1; lvl = 3'd7;
        @(negedge clk); nmi_req = 0;
        reg_write(7'h04, 16'h0A0A, 3'd2);
        wait_cyc(30);
        check("R9 two entries", ev_q.size(), 2);
        if (ev_q.size() == 2) begin
            check("R9 level entry finishes first", ev_q[0], 11);
            check("R9 held NMI served after", ev_q[1], 2);
        end
        slow_ready = 0;
        wait_cyc(4);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule